// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block controls the copying of data between a fast volatile array and its nonvolatile shadow copy. It reacts to four sources. A power-up event always reloads the array from the shadow. A power-fail event saves the array, but only when automatic saving is enabled. A falling edge on an active-low, shared handshake line also requests a save. Software commands can request a save or a reload, or switch automatic saving on or off.

While any of these operations runs, the block disables the array and pulls the handshake line low. It then releases both once the operation is over. A dirty flag records whether the array has been written since the last save, and any save request is skipped while that flag is clear. The copy itself happens outside the block. The block only marks its start with one-cycle strobes and its end with a done strobe. All durations are parameters expressed in clock cycles.

The handshake line is split into a sampled input level and a drive-low enable. The wired line outside the block combines the two.

Top module: `nvsr_ctrl`

## Requirements
- R1: After synchronous reset the array is enabled, the handshake line is not driven, the dirty flag is 0 and the auto-save flag equals AUTO_RST (1 by default).
- R2: A write while idle sets the dirty flag. A completed save clears it.
- R3: A power-up event while idle starts a reload of RCL_PWR_CYC cycles. The reload strobe comes in its first cycle and the done strobe in its last.
- R4: A power-fail event while idle starts a save only when auto-save is on and the dirty flag is set. A save is one grace cycle followed by STORE_CYC cycles, with the save strobe in the first of those cycles. Otherwise the event is ignored.
- R5: A falling edge on the handshake line while idle starts a save if the dirty flag is set. If the flag is clear, the block instead holds the line low for HS_HOLD_CYC cycles and does no save.
- R6: Software command code 0 (save) behaves like R5: a save if the dirty flag is set, otherwise a busy wait of CMD_WAIT_CYC cycles with no save.
- R7: Software command code 1 (reload) starts a reload of RCL_CMD_CYC cycles.
- R8: Command code 2 turns auto-save on and code 3 turns it off, each followed by a busy wait of CMD_WAIT_CYC cycles. No other input changes the auto-save flag.
- R9: While busy, all requests, commands and writes are ignored.
- R10: When requests arrive in the same idle cycle, the priority order is power-up, then power-fail, then handshake edge, then software command.
- R11: A write in the same cycle as a save request counts as dirty for that request.
- R12: The handshake line is driven low exactly while the array is disabled, and every transfer strobe falls inside that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up | input | 1 | Power-up event pulse |
| pwr_fail | input | 1 | Power-fail event pulse |
| cmd_valid | input | 1 | Software command valid |
| cmd | input | 2 | Command code: 0 save, 1 reload, 2 auto on, 3 auto off |
| array_wr | input | 1 | A write to the array in this cycle |
| hs_in | input | 1 | Sampled level of the shared handshake line |
| hs_drive_low | output | 1 | Pull the handshake line low |
| array_en | output | 1 | Array accessible (block idle) |
| nv_store_go | output | 1 | Save transfer start strobe |
| nv_recall_go | output | 1 | Reload transfer start strobe |
| nv_xfer_done | output | 1 | Last cycle of a save or reload |
| wr_latch | output | 1 | Dirty flag |
| auto_en | output | 1 | Auto-save flag |

## Verification
The bench sets the phase lengths to 6 (save), 9 (power-up reload), 4 (command reload), 3 (command wait) and 2 (handshake hold) cycles. The real millisecond-scale counts would take far too long to simulate. Because every phase length differs, the length of a busy window tells which operation ran, so priority, skipped saves and ignored requests can all be told apart from the ports alone. The save window is 7 cycles, one more than the save length, because of the grace cycle.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GRACE,
        PH_STORE,
        PH_RCL_PWR,
        PH_RCL_CMD,
        PH_CMD_WAIT,
        PH_HS_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        CMD_SAVE     = 2'd0,
        CMD_RELOAD   = 2'd1,
        CMD_AUTO_ON  = 2'd2,
        CMD_AUTO_OFF = 2'd3
    } cmd_e;

    typedef struct packed {
        logic   start;
        phase_e first;
        logic   auto_set;
        logic   auto_clr;
    } launch_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_transfer(input phase_e p);
        return (p == PH_STORE) || (p == PH_RCL_PWR) || (p == PH_RCL_CMD);
    endfunction

endpackage

// File: rtl/nvsr_arbiter.sv
module nvsr_arbiter
    import nvsr_pkg::*;
(
    input  logic       pwr_up,
    input  logic       pwr_fail,
    input  logic       hs_fall,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  logic       dirty,
    input  logic       auto_en,
    output launch_t    launch
);
    always_comb begin
        launch = '{start: 1'b0, first: PH_IDLE, auto_set: 1'b0, auto_clr: 1'b0};
        if (pwr_up) begin
            launch.start = 1'b1;
            launch.first = PH_RCL_PWR;
        end else if (pwr_fail && auto_en && dirty) begin
            launch.start = 1'b1;
            launch.first = PH_GRACE;
        end else if (hs_fall) begin
            launch.start = 1'b1;
            launch.first = dirty ? PH_GRACE : PH_HS_HOLD;
        end else if (cmd_valid) begin
            launch.start = 1'b1;
            unique case (cmd_e'(cmd))
                CMD_SAVE:     launch.first = dirty ? PH_GRACE : PH_CMD_WAIT;
                CMD_RELOAD:   launch.first = PH_RCL_CMD;
                CMD_AUTO_ON: begin
                    launch.first    = PH_CMD_WAIT;
                    launch.auto_set = 1'b1;
                end
                CMD_AUTO_OFF: begin
                    launch.first    = PH_CMD_WAIT;
                    launch.auto_clr = 1'b1;
                end
                default:      launch.first = PH_CMD_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/nvsr_timer.sv
module nvsr_timer
    import nvsr_pkg::*;
#(
    parameter int unsigned STORE_CYC    = 800000,
    parameter int unsigned RCL_PWR_CYC  = 2000000,
    parameter int unsigned RCL_CMD_CYC  = 20000,
    parameter int unsigned CMD_WAIT_CYC = 10000,
    parameter int unsigned HS_HOLD_CYC  = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e cur,
    input  phase_e nxt,
    output logic   first,
    output logic   last
);
    localparam int unsigned MAXC =
        max_u(max_u(STORE_CYC, RCL_PWR_CYC), max_u(max_u(RCL_CMD_CYC, CMD_WAIT_CYC), HS_HOLD_CYC));
    localparam int CW = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    int unsigned   len;

    always_comb begin
        unique case (cur)
            PH_STORE:    len = STORE_CYC;
            PH_RCL_PWR:  len = RCL_PWR_CYC;
            PH_RCL_CMD:  len = RCL_CMD_CYC;
            PH_CMD_WAIT: len = CMD_WAIT_CYC;
            PH_HS_HOLD:  len = HS_HOLD_CYC;
            default:     len = 1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || cur == PH_IDLE || nxt != cur) cnt <= '0;
        else                                     cnt <= cnt + 1'b1;
    end

    assign first = (cnt == '0);
    assign last  = (32'(cnt) == len - 1);
endmodule

// File: rtl/nvsr_flags.sv
module nvsr_flags #(
    parameter logic AUTO_RST = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_set,
    input  logic store_clr,
    input  logic auto_set,
    input  logic auto_clr,
    output logic wr_latch,
    output logic auto_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_latch <= 1'b0;
            auto_en  <= AUTO_RST;
        end else begin
            if (store_clr)   wr_latch <= 1'b0;
            else if (wr_set) wr_latch <= 1'b1;
            if (auto_set)      auto_en <= 1'b1;
            else if (auto_clr) auto_en <= 1'b0;
        end
    end
endmodule

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl
    import nvsr_pkg::*;
#(
    parameter int unsigned STORE_CYC    = 800000,
    parameter int unsigned RCL_PWR_CYC  = 2000000,
    parameter int unsigned RCL_CMD_CYC  = 20000,
    parameter int unsigned CMD_WAIT_CYC = 10000,
    parameter int unsigned HS_HOLD_CYC  = 4,
    parameter logic        AUTO_RST     = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_up,
    input  logic       pwr_fail,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  logic       array_wr,
    input  logic       hs_in,
    output logic       hs_drive_low,
    output logic       array_en,
    output logic       nv_store_go,
    output logic       nv_recall_go,
    output logic       nv_xfer_done,
    output logic       wr_latch,
    output logic       auto_en
);
    phase_e  state, nxt;
    launch_t launch;
    logic    hs_prev, hs_fall, first, last, idle;

    assign idle    = (state == PH_IDLE);
    assign hs_fall = hs_prev && !hs_in;

    always_ff @(posedge clk) begin
        if (rst) hs_prev <= 1'b1;
        else     hs_prev <= hs_in;
    end

    nvsr_arbiter u_arb (
        .pwr_up    (pwr_up),
        .pwr_fail  (pwr_fail),
        .hs_fall   (hs_fall),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .dirty     (wr_latch || array_wr),
        .auto_en   (auto_en),
        .launch    (launch)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE:  if (launch.start) nxt = launch.first;
            PH_GRACE: nxt = PH_STORE;
            default:  if (last) nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PH_IDLE;
        else     state <= nxt;
    end

    nvsr_timer #(
        .STORE_CYC    (STORE_CYC),
        .RCL_PWR_CYC  (RCL_PWR_CYC),
        .RCL_CMD_CYC  (RCL_CMD_CYC),
        .CMD_WAIT_CYC (CMD_WAIT_CYC),
        .HS_HOLD_CYC  (HS_HOLD_CYC)
    ) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .cur   (state),
        .nxt   (nxt),
        .first (first),
        .last  (last)
    );

    nvsr_flags #(.AUTO_RST(AUTO_RST)) u_flg (
        .clk       (clk),
        .rst       (rst),
        .wr_set    (idle && array_wr),
        .store_clr (state == PH_STORE && last),
        .auto_set  (idle && launch.auto_set),
        .auto_clr  (idle && launch.auto_clr),
        .wr_latch  (wr_latch),
        .auto_en   (auto_en)
    );

    assign array_en     = idle;
    assign hs_drive_low = !idle;
    assign nv_store_go  = (state == PH_STORE) && first;
    assign nv_recall_go = (state == PH_RCL_PWR || state == PH_RCL_CMD) && first;
    assign nv_xfer_done = is_transfer(state) && last;
endmodule

// File: rtl/nvsr_ctrl_chk.sv
module nvsr_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic pwr_up,
    input logic pwr_fail,
    input logic cmd_valid,
    input logic array_wr,
    input logic hs_in,
    input logic hs_drive_low,
    input logic array_en,
    input logic nv_store_go,
    input logic nv_recall_go,
    input logic wr_latch,
    input logic auto_en
);
    // R1
    rst_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (array_en && !hs_drive_low && !wr_latch));

    // R2
    dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
        (array_en && array_wr) |=> wr_latch);

    // R3
    pwr_up_chk: assert property (@(posedge clk) disable iff (rst)
        (array_en && pwr_up) |=> nv_recall_go);

    // R4
    pf_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (array_en && pwr_fail && !auto_en && !pwr_up && !cmd_valid && hs_in) |=> array_en);

    // R4
    grace_chk: assert property (@(posedge clk) disable iff (rst)
        nv_store_go |-> $past(!array_en));

    // R9
    busy_auto_chk: assert property (@(posedge clk) disable iff (rst)
        !array_en |=> $stable(auto_en));

    // R12
    strobe_window_chk: assert property (@(posedge clk) disable iff (rst)
        (nv_store_go || nv_recall_go) |-> (hs_drive_low && !array_en));
endmodule

bind nvsr_ctrl nvsr_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_up       (pwr_up),
    .pwr_fail     (pwr_fail),
    .cmd_valid    (cmd_valid),
    .array_wr     (array_wr),
    .hs_in        (hs_in),
    .hs_drive_low (hs_drive_low),
    .array_en     (array_en),
    .nv_store_go  (nv_store_go),
    .nv_recall_go (nv_recall_go),
    .wr_latch     (wr_latch),
    .auto_en      (auto_en)
);

// File: tb/sim_nvsr_ctrl.sv
`timescale 1ns/1ps
module sim_nvsr_ctrl;
    localparam int T_ST = 6, T_RP = 9, T_RC = 4, T_CW = 3, T_HH = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic pwr_up = 0, pwr_fail = 0, cmd_valid = 0, array_wr = 0, ext_low = 0;
    logic [1:0] cmd = 0;
    logic hs_in, hs_drive_low, array_en, nv_store_go, nv_recall_go, nv_xfer_done, wr_latch, auto_en;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    assign hs_in = !(ext_low || hs_drive_low);

    nvsr_ctrl #(.STORE_CYC(T_ST), .RCL_PWR_CYC(T_RP), .RCL_CMD_CYC(T_RC),
                .CMD_WAIT_CYC(T_CW), .HS_HOLD_CYC(T_HH), .AUTO_RST(1'b1)) u0 (
        .clk(clk), .rst(rst), .pwr_up(pwr_up), .pwr_fail(pwr_fail), .cmd_valid(cmd_valid),
        .cmd(cmd), .array_wr(array_wr), .hs_in(hs_in), .hs_drive_low(hs_drive_low),
        .array_en(array_en), .nv_store_go(nv_store_go), .nv_recall_go(nv_recall_go),
        .nv_xfer_done(nv_xfer_done), .wr_latch(wr_latch), .auto_en(auto_en));

    typedef struct packed {
        logic [3:0] mask;   // {sw, hw, fail, up}
        logic [1:0] arg;
        logic       pre_wr;
        logic [7:0] busy;
        logic [1:0] n_st;
        logic [1:0] n_rc;
        logic       latch;
        logic       ae;
    } vec_t;

    function automatic vec_t mk(input logic [3:0] m, input logic [1:0] a, input logic w,
                                input int b, input int s, input int r, input logic l, input logic e);
        return '{mask: m, arg: a, pre_wr: w, busy: 8'(b), n_st: 2'(s), n_rc: 2'(r), latch: l, ae: e};
    endfunction

    localparam vec_t TBL [13] = '{
        mk(4'b0001, 2'd0, 0, T_RP,   0, 1, 0, 1), // R3 power-up reload
        mk(4'b0010, 2'd0, 0, 0,      0, 0, 0, 1), // R4 clean: ignored
        mk(4'b0010, 2'd0, 1, T_ST+1, 1, 0, 0, 1), // R4 R2 dirty save
        mk(4'b0100, 2'd0, 0, T_HH,   0, 0, 0, 1), // R5 clean: hold
        mk(4'b0100, 2'd0, 1, T_ST+1, 1, 0, 0, 1), // R5 dirty save
        mk(4'b1000, 2'd0, 0, T_CW,   0, 0, 0, 1), // R6 clean wait
        mk(4'b1000, 2'd0, 1, T_ST+1, 1, 0, 0, 1), // R6 dirty save
        mk(4'b1000, 2'd1, 0, T_RC,   0, 1, 0, 1), // R7 reload
        mk(4'b1000, 2'd3, 0, T_CW,   0, 0, 0, 0), // R8 auto off
        mk(4'b0010, 2'd0, 1, 0,      0, 0, 1, 0), // R4 auto off: ignored
        mk(4'b1000, 2'd2, 0, T_CW,   0, 0, 1, 1), // R8 auto on
        mk(4'b0010, 2'd0, 0, T_ST+1, 1, 0, 0, 1), // R4 R2 save clears dirty
        mk(4'b0001, 2'd0, 0, T_RP,   0, 1, 0, 1)  // R3 again
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_write();
        @(negedge clk); array_wr = 1;
        @(posedge clk); @(negedge clk); array_wr = 0;
    endtask

    task automatic fire(input logic [3:0] m, input logic [1:0] a, input logic same_wr);
        @(negedge clk);
        pwr_up = m[0]; pwr_fail = m[1]; ext_low = m[2]; cmd_valid = m[3]; cmd = a; array_wr = same_wr;
        @(posedge clk);
        @(negedge clk);
        pwr_up = 0; pwr_fail = 0; ext_low = 0; cmd_valid = 0; array_wr = 0;
    endtask

    task automatic measure(output int busy, output int st, output int rc, output int dn, output int mis);
        busy = 0; st = 0; rc = 0; dn = 0; mis = 0;
        while (!array_en && busy < 200) begin
            busy++;
            st += int'(nv_store_go);
            rc += int'(nv_recall_go);
            dn += int'(nv_xfer_done);
            if (hs_drive_low == array_en) mis++;
            @(negedge clk);
        end
        if (hs_drive_low == array_en) mis++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int b, s, r, d, mm;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk(array_en == 1 && hs_drive_low == 0, "R1 idle after reset", int'(array_en), 1);
        chk(wr_latch == 0, "R1 dirty flag reset", int'(wr_latch), 0);
        chk(auto_en == 1, "R1 auto flag reset", int'(auto_en), 1);

        foreach (TBL[i]) begin
            if (TBL[i].pre_wr) do_write();
            fire(TBL[i].mask, TBL[i].arg, 1'b0);
            measure(b, s, r, d, mm);
            chk(b == int'(TBL[i].busy), $sformatf("vec%0d busy length", i), b, int'(TBL[i].busy));
            chk(s == int'(TBL[i].n_st), $sformatf("vec%0d save strobes", i), s, int'(TBL[i].n_st));
            chk(r == int'(TBL[i].n_rc), $sformatf("vec%0d reload strobes", i), r, int'(TBL[i].n_rc));
            chk(d == s + r, $sformatf("vec%0d done strobes", i), d, s + r);
            chk(mm == 0, $sformatf("R12 vec%0d pin vs enable", i), mm, 0);
            chk(wr_latch == TBL[i].latch, $sformatf("R2 vec%0d dirty flag", i), int'(wr_latch), int'(TBL[i].latch));
            chk(auto_en == TBL[i].ae, $sformatf("R8 vec%0d auto flag", i), int'(auto_en), int'(TBL[i].ae));
        end

        // R11: write in the same cycle as a software save
        fire(4'b1000, 2'd0, 1'b1);
        measure(b, s, r, d, mm);
        chk(b == T_ST + 1 && s == 1, "R11 same-cycle write saves", b, T_ST + 1);
        chk(wr_latch == 0, "R11 dirty cleared", int'(wr_latch), 0);

        // R10: all sources at once -> power-up reload wins
        do_write();
        fire(4'b1111, 2'd1, 1'b0);
        measure(b, s, r, d, mm);
        chk(b == T_RP && r == 1 && s == 0, "R10 power-up first", b, T_RP);
        chk(wr_latch == 1, "R10 dirty kept", int'(wr_latch), 1);

        // R10: power-fail beats handshake and command
        fire(4'b1110, 2'd1, 1'b0);
        measure(b, s, r, d, mm);
        chk(b == T_ST + 1 && s == 1 && r == 0, "R10 power-fail before others", b, T_ST + 1);

        // R10: handshake edge beats software reload
        do_write();
        fire(4'b1100, 2'd1, 1'b0);
        measure(b, s, r, d, mm);
        chk(b == T_ST + 1 && s == 1 && r == 0, "R10 handshake before command", b, T_ST + 1);

        // R9: requests during a busy wait are ignored
        fire(4'b1000, 2'd2, 1'b0);
        pwr_up = 1; cmd_valid = 1; cmd = 2'd3; array_wr = 1; ext_low = 1;
        @(posedge clk); @(negedge clk);
        pwr_up = 0; cmd_valid = 0; array_wr = 0; ext_low = 0;
        measure(b, s, r, d, mm);
        chk(b == T_CW - 1 && s == 0 && r == 0, "R9 busy wait unchanged", b, T_CW - 1);
        chk(wr_latch == 0, "R9 write ignored", int'(wr_latch), 0);
        chk(auto_en == 1, "R9 command ignored", int'(auto_en), 1);
        repeat (2) @(negedge clk);
        chk(array_en == 1, "R9 nothing queued", int'(array_en), 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule